// File: doc/BRIEF.md
# Unsigned Array Multiplier with (4,2) Compressor Reduction

This block multiplies two unsigned operands of equal width and returns the full double-width product in the same cycle. It has no clock. The operand width is a parameter, and the block is built for 4-bit and 8-bit operands.

Each bit of the multiplier gates a shifted copy of the multiplicand, which gives one partial-product row per multiplier bit. Groups of four rows pass through a row of (4,2) compressors, and each group comes out as two rows. Each compressor is built from two full adders. Neighbouring compressors in a row are linked by a lateral carry: the internal carry-out of one bit position feeds the internal carry-in of the next higher position. The lowest position has its lateral carry-in tied to zero. Unused high-order inputs are padded with zeros.

For 8-bit operands a second compressor layer reduces four rows to two. With 4-bit operands one layer is enough. A ripple carry-propagate adder sums the final two rows into the product.

Top module: `csa42_multiplier`

## Requirements
- R1: With OPW=4, prod_o equals a_i*b_i for every one of the 256 operand pairs.
- R2: With OPW=8, prod_o equals a_i*b_i for any operand pair, as a 16-bit unsigned value.
- R3: When either operand is zero, prod_o is zero.
- R4: All-ones operands give the largest product: 225 (0xE1) for OPW=4 and 65025 (0xFE01) for OPW=8.
- R5: In each (4,2) compressor, the four inputs plus the lateral carry-in add up to s + 2*(c + cout). Here cout is the lateral carry-out taken from the first full adder, and c is the carry from the second full adder.
- R6: Each compressor row turns four rows into two rows with no loss. The sum of the four input rows equals the sum row, plus the carry row shifted up by one bit, plus the top lateral carry at weight 2^(2*OPW). The lateral carry-in of bit 0 is zero.
- R7: Partial-product row i equals the multiplicand shifted left by i when bit i of the multiplier is 1, and is zero otherwise. So a multiplier of 2^k gives prod_o = a_i << k.
- R8: The final adder output equals the sum of the two reduced rows, modulo 2^(2*OPW).
- R9: A multiplier of 1 returns the multiplicand, and a multiplicand of 1 returns the multiplier, both zero-extended.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | OPW | Multiplicand, unsigned |
| b_i | input | OPW | Multiplier, unsigned |
| prod_o | output | 2*OPW | Full-width unsigned product |

## Verification
The bench builds two copies of the block side by side, one with OPW=4 and one with OPW=8. The 4-bit copy is small enough to cover its whole operand space. This exercises every carry pattern through its single compressor layer. The 8-bit copy reaches the two-layer reduction, where the lateral carries of the first layer meet a second layer. Random pairs, powers of two and all-ones operands cover this copy.

// File: rtl/mul42_pkg.sv
package mul42_pkg;

  typedef struct packed {
    logic co;
    logic s;
  } fa_t;

  // (3,2) counter written with gates: sum bit and carry bit
  function automatic fa_t fa3(input logic x, input logic y, input logic z);
    fa_t r;
    r.s  = x ^ y ^ z;
    r.co = (x & y) | (z & (x ^ y));
    return r;
  endfunction

endpackage

// File: rtl/compressor42.sv
module compressor42
  import mul42_pkg::*;
(
  input  logic [3:0] x,
  input  logic       cin,
  output logic       s,
  output logic       c,
  output logic       cout
);

  fa_t first_fa;
  fa_t second_fa;

  // first adder takes three external inputs; its carry leaves sideways
  assign first_fa  = fa3(x[0], x[1], x[2]);
  // second adder merges the partial sum, the fourth input and the lateral carry
  assign second_fa = fa3(first_fa.s, x[3], cin);

  assign s    = second_fa.s;
  assign c    = second_fa.co;
  assign cout = first_fa.co;

  logic [2:0] in_weight;
  logic [2:0] out_weight;

  always_comb begin
    in_weight  = 3'(x[0]) + 3'(x[1]) + 3'(x[2]) + 3'(x[3]) + 3'(cin);
    out_weight = 3'(s) + 3'({c, 1'b0}) + 3'({cout, 1'b0});
    AST_COMP_WEIGHT: assert (in_weight == out_weight) else $error("compressor weight mismatch"); // R5
  end

endmodule

// File: rtl/comp_row.sv
module comp_row #(
  parameter int W = 16
) (
  input  logic [3:0][W-1:0] rows_i,
  output logic [W-1:0]      sum_o,
  output logic [W-1:0]      car_o
);

  localparam int XW = W + 2;

  logic [W:0]   lat;   // lateral carry chain between neighbouring columns
  logic [W-1:0] cw;    // carry outputs, weight one above their column

  assign lat[0] = 1'b0;

  genvar i;
  generate
    for (i = 0; i < W; i++) begin : g_col
      compressor42 u_cmp (
        .x    ({rows_i[3][i], rows_i[2][i], rows_i[1][i], rows_i[0][i]}),
        .cin  (lat[i]),
        .s    (sum_o[i]),
        .c    (cw[i]),
        .cout (lat[i+1])
      );
    end
  endgenerate

  assign car_o = {cw[W-2:0], 1'b0};

  logic [XW-1:0] in_total;
  logic [XW-1:0] out_total;

  always_comb begin
    in_total  = XW'(rows_i[0]) + XW'(rows_i[1]) + XW'(rows_i[2]) + XW'(rows_i[3]);
    out_total = XW'(sum_o) + (XW'(cw) << 1) + (XW'(lat[W]) << W);
    AST_LAYER_LOSSLESS: assert (in_total == out_total) else $error("layer sum mismatch"); // R6
  end

endmodule

// File: rtl/cpa_ripple.sv
module cpa_ripple
  import mul42_pkg::*;
#(
  parameter int W = 16
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);

  always_comb begin
    logic cy;
    fa_t  t;
    cy = 1'b0;
    for (int k = 0; k < W; k++) begin
      t        = fa3(x_i[k], y_i[k], cy);
      sum_o[k] = t.s;
      cy       = t.co;
    end
    AST_CPA_SUM: assert (sum_o == x_i + y_i) else $error("final adder mismatch"); // R8
  end

endmodule

// File: rtl/csa42_multiplier.sv
module csa42_multiplier #(
  parameter int OPW = 8
) (
  input  logic [OPW-1:0]   a_i,
  input  logic [OPW-1:0]   b_i,
  output logic [2*OPW-1:0] prod_o
);

  localparam int PW    = 2 * OPW;
  localparam int LVLS  = $clog2(OPW) - 1;   // compressor layers
  localparam int NROWS = 2 * OPW - 2;       // rows over all layers
  localparam int LASTB = NROWS - 2;         // first of the two final rows

  function automatic logic [PW-1:0] pp_row(input logic [OPW-1:0] m,
                                           input logic sel, input int sh);
    return sel ? (PW'(m) << sh) : '0;
  endfunction

  // rows of layer l start at 2*OPW - 2*(OPW>>l)
  logic [PW-1:0] rowv [NROWS];

  genvar i, l, g;
  generate
    for (i = 0; i < OPW; i++) begin : g_pp
      assign rowv[i] = pp_row(a_i, b_i[i], i);   // R7
    end

    for (l = 0; l < LVLS; l++) begin : g_lvl
      for (g = 0; g < ((OPW >> l) / 4); g++) begin : g_grp
        localparam int IB = 2*OPW - 2*(OPW >> l) + 4*g;
        localparam int OB = 2*OPW - 2*(OPW >> (l+1)) + 2*g;
        comp_row #(.W(PW)) u_row (
          .rows_i ({rowv[IB+3], rowv[IB+2], rowv[IB+1], rowv[IB]}),
          .sum_o  (rowv[OB]),
          .car_o  (rowv[OB+1])
        );
      end
    end
  endgenerate

  cpa_ripple #(.W(PW)) u_cpa (
    .x_i   (rowv[LASTB]),
    .y_i   (rowv[LASTB+1]),
    .sum_o (prod_o)
  );

  always_comb begin
    AST_PRODUCT_EXACT: assert (prod_o == PW'(a_i) * PW'(b_i)) else $error("product mismatch"); // R2
  end

endmodule

// File: tb/csa42_multiplier_test.sv
module csa42_multiplier_test;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;   // 200 MHz

  logic [7:0]  a8 = '0, b8 = '0;
  logic [15:0] p8;
  logic [3:0]  a4 = '0, b4 = '0;
  logic [7:0]  p4;

  csa42_multiplier #(.OPW(8)) uut       (.a_i(a8), .b_i(b8), .prod_o(p8));
  csa42_multiplier #(.OPW(4)) uut_small (.a_i(a4), .b_i(b4), .prod_o(p4));

  int n_cmp = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;

  function automatic logic [15:0] ref8(input logic [7:0] x, input logic [7:0] y);
    logic [15:0] acc = '0;
    for (int k = 0; k < 8; k++) if (y[k]) acc += 16'(x) << k;
    return acc;
  endfunction

  function automatic logic [7:0] ref4(input logic [3:0] x, input logic [3:0] y);
    logic [7:0] acc = '0;
    for (int k = 0; k < 4; k++) if (y[k]) acc += 8'(x) << k;
    return acc;
  endfunction

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run8(input string tag, input logic [7:0] x, input logic [7:0] y);
    @(posedge clk); a8 = x; b8 = y;
    @(negedge clk); chk(tag, p8, ref8(x, y));
  endtask

  task automatic run4(input string tag, input logic [3:0] x, input logic [3:0] y);
    @(posedge clk); a4 = x; b4 = y;
    @(negedge clk); chk(tag, {8'h0, p4}, {8'h0, ref4(x, y)});
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 reset-time zero operands 8b", p8, 16'h0000);
    chk("R3 reset-time zero operands 4b", {8'h0, p4}, 16'h0000);
    rst = 1'b0;

    // R1: exhaustive 4x4
    for (int x = 0; x < 16; x++)
      for (int y = 0; y < 16; y++)
        run4("R1 exhaustive 4b", 4'(x), 4'(y));

    // R3 zero operand
    run8("R3 zero multiplier", 8'hA7, 8'h00);
    run8("R3 zero multiplicand", 8'h00, 8'h5C);
    // R4 all ones
    run8("R4 all-ones 8b", 8'hFF, 8'hFF);
    chk("R4 all-ones value 8b", p8, 16'hFE01);
    run4("R4 all-ones 4b", 4'hF, 4'hF);
    chk("R4 all-ones value 4b", {8'h0, p4}, 16'h00E1);
    // R7 powers of two select one row
    for (int k = 0; k < 8; k++) begin
      run8("R7 single partial row", 8'hB5, 8'(1 << k));
      chk("R7 shifted multiplicand", p8, 16'(16'h00B5 << k));
    end
    // R9 identity
    run8("R9 multiply by one", 8'hC3, 8'h01);
    chk("R9 identity value", p8, 16'h00C3);
    run8("R9 one times operand", 8'h01, 8'h9E);
    chk("R9 identity value swapped", p8, 16'h009E);
    // dense carries through both layers
    run8("R2 R6 alternating bits", 8'hAA, 8'h55);
    run8("R2 R6 near-max", 8'hFE, 8'hFF);

    // R2 random 8x8; exercises R5 R6 R8 through the product
    for (int n = 0; n < 3000; n++)
      run8("R2 R5 R6 R8 random 8b", 8'($urandom), 8'($urandom));

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule